// File: doc/BRIEF.md
# Modem Handshake Change Detector

This block supplies the modem status register of a serial port. Four handshake lines arrive active low from the pins: clear to send, data set ready, ring indicator and carrier detect. Each line passes through its own synchroniser. The block then reports each line's present level as asserted-true and keeps a sticky flag per line that records a change since the last read. A processor reads the result as one 8-bit value. A read strobe clears the flags.

The ring indicator follows a different rule from the other lines. Its flag is set only when the ring signal ends, that is when the asserted level drops. It is not set when the ring signal starts. The other three lines set their flag on any change of level. A single level output tells the port's interrupt logic that at least one flag is set.

Top module: `modem_status_reg`

## Requirements
- R1: Bit 0 of `rd_data` becomes 1 when the synchronised `cts_n` level changes in either direction.
- R2: Bit 1 of `rd_data` becomes 1 when the synchronised `dsr_n` level changes in either direction.
- R3: Bit 2 of `rd_data` becomes 1 only when `ri_n` goes from low to high (the ring signal ends). A high-to-low change of `ri_n` leaves bit 2 unchanged.
- R4: Bit 3 of `rd_data` becomes 1 when the synchronised `dcd_n` level changes in either direction.
- R5: Bits 4, 5, 6 and 7 of `rd_data` show the inverted synchronised levels of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`, in that order, so a low pin reads as 1.
- R6: A change flag stays at 1 until a read clears it, even if its line changes again or returns to its earlier level.
- R7: `rd_data` shows the register combinationally during the read cycle. A clock edge with `rd_en` high clears all change flags, except for the case in R8.
- R8: A change that would set a flag on the same edge as a read leaves that flag at 1 after the read.
- R9: `status_event` is 1 exactly when at least one of bits 3 to 0 of `rd_data` is 1.
- R10: Reset clears all change flags. Pin levels already present when reset is released set no flag, and bits 7 to 4 settle to those levels.
- R11: A pin change driven before a rising edge shows in bits 7 to 4 after the second rising edge. It sets its change flag on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| rd_en | input | 1 | Register read strobe; clears the change flags at the clock edge |
| rd_data | output | 8 | Register value: change flags in bits 3:0, line levels in bits 7:4 |
| status_event | output | 1 | High while any change flag is set |

## Verification
On every cycle, the assertions check three things in each delta cell: flags stay set, reads clear them, and an edge that lands on a read is kept. They also check that the ring cell ignores a leading ring edge, that no flag appears before the post-reset settle window ends, and that the event output cannot rise without a detected edge. Some behaviour only the bench scenarios can show. This covers the exact bit position of each line, the inverted level bits, the three-edge latency from pin to flag, the mixed case where one flag clears while another is set on the same read, and the absence of spurious flags when pins are held asserted through reset.

// File: rtl/modem_status_pkg.sv
package modem_status_pkg;

  // Detection rule applied to one handshake line (asserted-true level).
  typedef enum logic {
    DET_ANY  = 1'b0,   // flag any change of level
    DET_FALL = 1'b1    // flag only the end of assertion (1 -> 0)
  } det_mode_e;

  localparam int LINE_COUNT = 4;
  localparam int IDX_CTS    = 0;
  localparam int IDX_DSR    = 1;
  localparam int IDX_RING   = 2;
  localparam int IDX_CD     = 3;

  function automatic det_mode_e mode_for_line(input int idx);
    return (idx == IDX_RING) ? DET_FALL : DET_ANY;
  endfunction

  // Next value of a sticky flag: a new edge wins over the clearing read.
  function automatic logic next_flag(input logic cur_flag, input logic edge_seen,
                                     input logic clr);
    return edge_seen | (cur_flag & ~clr);
  endfunction

  // Edge qualification for one line.
  function automatic logic edge_hit(input det_mode_e mode, input logic now_lvl,
                                    input logic old_lvl);
    if (mode == DET_FALL) return old_lvl & ~now_lvl;
    return now_lvl ^ old_lvl;
  endfunction

  function automatic logic [2*LINE_COUNT-1:0] pack_status(
      input logic [LINE_COUNT-1:0] lvl, input logic [LINE_COUNT-1:0] flg);
    return {lvl, flg};
  endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[s] <= RST_VAL;
        end else if (s == 0) begin
          chain_q[s] <= async_i;
        end else begin
          chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/msr_delta_cell.sv
module msr_delta_cell
  import modem_status_pkg::*;
#(
  parameter det_mode_e MODE = DET_ANY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,      // detection enabled once the synchroniser has settled
  input  logic clr,      // read strobe
  input  logic lvl,      // synchronised asserted-true level
  output logic flag_o,
  output logic evt_o     // qualified edge this cycle
);

  logic prev_q;
  logic flag_q;
  logic lead_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign evt_o    = arm & edge_hit(MODE, lvl, prev_q);
  assign lead_evt = arm & lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= next_flag(flag_q, evt_o, clr);
  end

  assign flag_o = flag_q;

  // R6: a set flag with no read stays set
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R7: a read with no simultaneous edge clears the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt_o) |=> !flag_q);

  // R8: an edge is never lost, even on a read edge
  a_r8_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> flag_q);

  generate
    if (MODE == DET_FALL) begin : g_trail_only
      // R3: the start of a ring does not raise a clear flag
      a_r3_no_leading: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_evt && !flag_q) |=> !flag_q);
    end
  endgenerate

endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import modem_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       status_event
);

  localparam int ARM_AT = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(ARM_AT + 1);

  logic [LINE_COUNT-1:0] pins_n;
  logic [LINE_COUNT-1:0] synced_n;
  logic [LINE_COUNT-1:0] level;
  logic [LINE_COUNT-1:0] flags;
  logic [LINE_COUNT-1:0] line_evt;
  logic [CNT_W-1:0]      settle_q;
  logic                  armed;

  assign pins_n = {dcd_n, ri_n, dsr_n, cts_n};

  msr_sync #(
    .WIDTH  (LINE_COUNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pins_n),
    .sync_o (synced_n)
  );

  assign level = ~synced_n;

  // Settle window: previous-level registers follow the synchroniser before
  // any edge may be flagged.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       settle_q <= '0;
    else if (!armed)  settle_q <= settle_q + 1'b1;
  end

  assign armed = (settle_q == CNT_W'(ARM_AT));

  genvar i;
  generate
    for (i = 0; i < LINE_COUNT; i++) begin : g_line
      msr_delta_cell #(
        .MODE(mode_for_line(i))
      ) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (armed),
        .clr   (rd_en),
        .lvl   (level[i]),
        .flag_o(flags[i]),
        .evt_o (line_evt[i])
      );
    end
  endgenerate

  assign rd_data      = pack_status(level, flags);
  assign status_event = |flags;

  // R10: no flag can appear before the settle window ends
  a_r10_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (rd_data[3:0] == 4'h0));

  // R9: the event output cannot rise without a detected edge
  a_r9_event_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_event && (line_evt == '0)) |=> !status_event);

  // R7: a read with no edge leaves the event output low
  a_r7_read_drops_event: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (line_evt == '0)) |=> !status_event);

endmodule

// File: tb/modem_status_reg_test.sv
`timescale 1ns/1ps
module modem_status_reg_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       status_event;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  modem_status_reg uut (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
    .dcd_n(dcd_n), .rd_en(rd_en), .rd_data(rd_data), .status_event(status_event)
  );

  // {pins as {dcd_n,ri_n,dsr_n,cts_n}, expected register after three edges}
  localparam logic [11:0] VECS [8] = '{
    {4'b1110, 8'h11},   // R1: CTS asserts
    {4'b1100, 8'h32},   // R2: DSR asserts
    {4'b1000, 8'h70},   // R3: ring starts, no flag
    {4'b1100, 8'h34},   // R3: ring ends, flag
    {4'b0100, 8'hB8},   // R4: carrier asserts
    {4'b1111, 8'h0B},   // R1 R2 R4: release
    {4'b0000, 8'hFB},   // R5: all asserted
    {4'b1111, 8'h0F}    // R3: all released, ring trailing
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp_v);
    end
  endtask

  task automatic set_pins(input logic [3:0] p);
    {dcd_n, ri_n, dsr_n, cts_n} = p;
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    // R10 reset state
    check8("R10 reset value", rd_data, 8'h00);
    check8("R9 reset event", {7'd0, status_event}, 8'h00);

    // Table walk: R1, R2, R3, R4, R5, R9, R11 then R7 clearing
    foreach (VECS[k]) begin
      set_pins(VECS[k][11:8]);
      repeat (3) @(negedge clk);
      check8("R1,R2,R3,R4,R5,R11 vector", rd_data, VECS[k][7:0]);
      check8("R9 vector event", {7'd0, status_event}, {7'd0, |VECS[k][3:0]});
      do_read();
      check8("R7 cleared after read", rd_data, {VECS[k][7:4], 4'h0});
      check8("R9 event after read", {7'd0, status_event}, 8'h00);
    end

    // R11: level after two edges, flag not yet; flag on third
    set_pins(4'b1110);
    repeat (2) @(negedge clk);
    check8("R11 level after two edges", rd_data, 8'h10);
    @(negedge clk);
    check8("R11 flag on third edge", rd_data, 8'h11);

    // R6: CTS goes back to idle, flag remains
    set_pins(4'b1111);
    repeat (3) @(negedge clk);
    check8("R6 sticky after return", rd_data, 8'h01);
    do_read();

    // R8: DSR flag pending, CTS edge lands on the read edge
    set_pins(4'b1101);
    repeat (3) @(negedge clk);
    check8("R2 dsr pending", rd_data, 8'h22);
    set_pins(4'b1100);
    repeat (2) @(negedge clk);
    check8("R7 read-cycle contents", rd_data, 8'h32);
    do_read();
    check8("R8 edge kept on read", rd_data, 8'h31);
    do_read();
    check8("R7 second read clears", rd_data, 8'h30);

    // R10: reset with pins held asserted
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check8("R10 in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check8("R10 no spurious flags", rd_data, 8'h30);
    check8("R10 event low", {7'd0, status_event}, 8'h00);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule